// File: doc/BRIEF.md
# Electronic Shutter Line-Count Controller

This block decides how long the image sensor integrates in each field. It does so by issuing substrate-discharge pulses (XSUB): one pulse at each of the first K horizontal lines after the field boundary. All charge collected before the last discharge pulse is thrown away, so a larger K gives a shorter exposure. The K used for a field is fixed at that field's boundary strobe and held until the next one. A setting that arrives mid-field therefore never splits a field between two exposures.

K comes from one of three sources, picked by static mode pins:
- **Auto iris**: a comparator result steps K by one line per field.
- **Parallel speed code**: a 3-bit code read from three shared speed pins.
- **Serial value**: an 8-bit value shifted in over the same three pins. The top pin carries data, the middle pin is the shift clock and the bottom pin is the load strobe.

A standard-select pin sets the field length, 262 lines or 312 lines, and selects the slowest parallel speed. The source selection is held in a four-state register:
- **ST_HALT**: XSUB disabled.
- **ST_IRIS**: auto iris.
- **ST_PAR**: parallel code.
- **ST_SER**: serial value.

Every clock the register moves to the state the pins call for. ST_HALT is entered whenever `xsub_en` is low. Otherwise ST_IRIS is entered when `iris_sel` is high, ST_PAR when `par_sel` is high, and ST_SER in every remaining case. Any state can move to any other.

Top module: `exposure_shutter_ctrl`

## Requirements
- R1: While `xsub_en` is low, `xsub` is low from the clock after `xsub_en` falls. In ST_HALT, a field boundary loads K = 0.
- R2: With `xsub_en` high and `iris_sel` high, the block uses auto-iris mode and `spd_pins` have no effect on K.
- R3: With `iris_sel` low, `par_sel` high selects the parallel code and `par_sel` low selects the serial value. The source that is not selected has no effect on K.
- R4: The parallel code is the 3-bit value `spd_pins`, bit 2 first. It gives E exposure lines, and K = L − E, or K = 0 when E > L:

  | Code | 0 | 1 | 2 | 3 | 4 | 5 | 6 | 7 |
  |---|---|---|---|---|---|---|---|---|
  | E | 0 | 2 | 3 | 8 | 16 | 31 | 63 | 157 with `std_ccir` low, 130 with `std_ccir` high |

- R5: The field length L is 262 with `std_ccir` low and 312 with `std_ccir` high. K never exceeds 312.
- R6: Each rising edge of the shift clock (`spd_pins[1]`) shifts `spd_pins[2]` into an 8-bit holding register, MSB first. A rising edge of the load strobe (`spd_pins[0]`) copies the holding register to the active value V. In serial mode K = L − V, so V = 00h is the fastest shutter.
- R7: `xsub` is a one-cycle pulse in the cycle after a `line_stb`. It is issued for exactly the first K line strobes after a `field_stb`, with none after them.
- R8: A changed setting affects K only at the next `field_stb`. K and the line count are unchanged between field strobes.
- R9: In auto-iris mode, each `field_stb` changes the iris count:
  - it rises by one when `iris_bright` is high and falls by one when it is low;
  - it is clamped to the range 0..L;
  - the stepped value becomes K for the new field.

  The count starts at 0 after reset and changes only at field strobes.
- R10: After reset: `xsub` is low, K is 0, and both serial registers hold 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_stb | input | 1 | One-cycle strobe at each field boundary (vertical transfer) |
| line_stb | input | 1 | One-cycle strobe per horizontal line |
| xsub_en | input | 1 | High enables discharge pulses and the source selection |
| iris_sel | input | 1 | High selects auto-iris control |
| par_sel | input | 1 | With iris_sel low: high selects parallel code, low selects serial value |
| std_ccir | input | 1 | Low: 262-line standard; high: 312-line standard |
| iris_bright | input | 1 | Iris comparator: high means too bright (more discharge) |
| spd_pins | input | 3 | Parallel speed code, or serial data/clock/strobe on bits 2/1/0 |
| xsub | output | 1 | Substrate-discharge pulse |

## Verification
The assertions rely on the following input conditions:
- `field_stb` and `line_stb` are single-cycle pulses that never coincide.
- Consecutive line strobes are separated by at least one idle cycle.
- The mode and standard pins change only well away from a field strobe.
- Each level on the serial pins lasts at least three clocks, so the two-flop synchronizer never misses or merges an edge.

The stimulus meets these conditions:
- Every line strobe is followed by an idle cycle.
- Mode and standard pins are set several cycles before the next field strobe.
- Each serial level is held for four clocks.
- Mid-field serial loads are made between line strobes.

Every field is checked on both the count of discharge pulses and their placement on lines 0..K−1.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_IRIS,
        ST_PAR,
        ST_SER
    } src_state_t;

    // Exposure lines for a 3-bit parallel speed code.
    function automatic int unsigned par_exposure(
        input logic [2:0]  code,
        input logic        ccir,
        input int unsigned slow_eia,
        input int unsigned slow_ccir
    );
        int unsigned e;
        unique case (code)
            3'd0:    e = 0;
            3'd1:    e = 2;
            3'd2:    e = 3;
            3'd3:    e = 8;
            3'd4:    e = 16;
            3'd5:    e = 31;
            3'd6:    e = 63;
            default: e = ccir ? slow_ccir : slow_eia;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] lvl
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            lvl  <= '0;
        end else begin
            meta <= pins;
            lvl  <= meta;
        end
    end
endmodule

// File: rtl/edge_rise.sv
module edge_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~prev[i];
    end
endmodule

// File: rtl/serial_loader.sv
module serial_loader #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdat,
    input  logic          shift_rise,
    input  logic          load_rise,
    output logic [DW-1:0] active
);
    logic [DW-1:0] hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold   <= '0;
            active <= '0;
        end else begin
            if (shift_rise) hold   <= {hold[DW-2:0], sdat};
            if (load_rise)  active <= hold;
        end
    end
endmodule

// File: rtl/iris_tracker.sv
module iris_tracker #(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          bright,
    input  logic [LW-1:0] limit,
    output logic [LW-1:0] k_nxt
);
    logic [LW-1:0] k;
    logic [LW-1:0] stepped;

    always_comb begin
        if (bright) stepped = (k >= limit) ? limit : k + 1'b1;
        else        stepped = (k == '0) ? '0 : k - 1'b1;
        k_nxt = (stepped > limit) ? limit : stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    k <= '0;
        else if (step) k <= k_nxt;
    end
endmodule

// File: rtl/exposure_shutter_ctrl.sv
module exposure_shutter_ctrl
    import shutter_pkg::*;
#(
    parameter int LINES_EIA     = 262,
    parameter int LINES_CCIR    = 312,
    parameter int SER_W         = 8,
    parameter int EXP_SLOW_EIA  = 157,
    parameter int EXP_SLOW_CCIR = 130
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_stb,
    input  logic       line_stb,
    input  logic       xsub_en,
    input  logic       iris_sel,
    input  logic       par_sel,
    input  logic       std_ccir,
    input  logic       iris_bright,
    input  logic [2:0] spd_pins,
    output logic       xsub
);
    localparam int LMAX = (LINES_CCIR > LINES_EIA) ? LINES_CCIR : LINES_EIA;
    localparam int LW   = $clog2(LMAX + 1);

    src_state_t    state, state_nxt;
    logic [2:0]    pin_lvl;
    logic [1:0]    pin_rise;
    logic [SER_W-1:0] ser_val;
    logic [LW-1:0] lines;
    logic [LW-1:0] iris_nxt;
    logic [LW-1:0] exp_sel;
    logic [LW-1:0] k_sel;
    logic [LW-1:0] k_field;
    logic [LW-1:0] line_cnt;
    logic          iris_step;

    pin_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .pins(spd_pins), .lvl(pin_lvl)
    );

    edge_rise #(.W(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_lvl[1:0]), .rise(pin_rise)
    );

    serial_loader #(.DW(SER_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .sdat(pin_lvl[2]),
        .shift_rise(pin_rise[1]), .load_rise(pin_rise[0]), .active(ser_val)
    );

    assign lines = std_ccir ? LW'(LINES_CCIR) : LW'(LINES_EIA);

    iris_tracker #(.LW(LW)) u_iris (
        .clk(clk), .rst_n(rst_n), .step(iris_step), .bright(iris_bright),
        .limit(lines), .k_nxt(iris_nxt)
    );

    // Source selection: priority enable > iris > parallel > serial
    always_comb begin
        if (!xsub_en)     state_nxt = ST_HALT;
        else if (iris_sel) state_nxt = ST_IRIS;
        else if (par_sel)  state_nxt = ST_PAR;
        else               state_nxt = ST_SER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nxt;
    end

    // Per-state outputs: K candidate and iris stepping
    always_comb begin
        iris_step = 1'b0;
        exp_sel   = '0;
        k_sel     = '0;
        unique case (state)
            ST_HALT: k_sel = '0;
            ST_IRIS: begin
                iris_step = field_stb;
                k_sel     = iris_nxt;
            end
            ST_PAR: begin
                exp_sel = LW'(par_exposure(pin_lvl, std_ccir,
                                           EXP_SLOW_EIA, EXP_SLOW_CCIR));
                k_sel   = (exp_sel > lines) ? '0 : lines - exp_sel;
            end
            ST_SER: begin
                exp_sel = LW'(ser_val);
                k_sel   = (exp_sel > lines) ? '0 : lines - exp_sel;
            end
        endcase
    end

    // Field latch and line counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_field  <= '0;
            line_cnt <= '0;
        end else if (field_stb) begin
            k_field  <= k_sel;
            line_cnt <= '0;
        end else if (line_stb && line_cnt != '1) begin
            line_cnt <= line_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xsub <= 1'b0;
        else        xsub <= line_stb && xsub_en && (state != ST_HALT)
                            && (line_cnt < k_field);
    end
endmodule

// File: rtl/shutter_checker.sv
module shutter_checker #(
    parameter int LW   = 9,
    parameter int LMAX = 312
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xsub_en,
    input logic          line_stb,
    input logic          field_stb,
    input logic          xsub,
    input logic [LW-1:0] k_field,
    input logic [LW-1:0] iris_k
);
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xsub_en |=> !xsub);                                       // R1
    AST_PULSE_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        xsub |-> $past(line_stb));                                 // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        xsub |=> !xsub);                                           // R7
    AST_K_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        k_field <= LW'(LMAX));                                     // R5
    AST_K_HELD_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> $stable(k_field));                          // R8
    AST_IRIS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        iris_k <= LW'(LMAX));                                      // R9
    AST_IRIS_STEPS_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_stb |=> $stable(iris_k));                           // R9
endmodule

bind exposure_shutter_ctrl shutter_checker #(.LW(LW), .LMAX(LMAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .xsub_en(xsub_en), .line_stb(line_stb),
    .field_stb(field_stb), .xsub(xsub), .k_field(k_field),
    .iris_k(u_iris.k)
);

// File: tb/tb_exposure_shutter_ctrl.sv
`timescale 1ns/1ps
module tb_exposure_shutter_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_stb = 1'b0, line_stb = 1'b0;
    logic xsub_en = 1'b0, iris_sel = 1'b0, par_sel = 1'b0;
    logic std_ccir = 1'b0, iris_bright = 1'b0;
    logic [2:0] spd_pins = 3'b000;
    logic xsub;

    int n_vec = 0, n_bad = 0;
    int pulses = 0, cur_line = 0;
    bit bad_pos = 1'b0;
    bit done = 1'b0;
    int ik = 0;

    always #2.5 clk = ~clk;

    exposure_shutter_ctrl dut (
        .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_stb(line_stb),
        .xsub_en(xsub_en), .iris_sel(iris_sel), .par_sel(par_sel),
        .std_ccir(std_ccir), .iris_bright(iris_bright), .spd_pins(spd_pins),
        .xsub(xsub)
    );

    always @(negedge clk) begin
        if (xsub) begin
            if (cur_line != pulses) bad_pos = 1'b1;
            pulses++;
        end
    end

    function automatic int lines_of(input bit c);
        return c ? 312 : 262;
    endfunction

    function automatic int exp_par(input int code, input bit c);
        int t[8] = '{0, 2, 3, 8, 16, 31, 63, 157};
        if (code == 7 && c) return 130;
        return t[code];
    endfunction

    function automatic int k_of(input int e, input bit c);
        return (e > lines_of(c)) ? 0 : lines_of(c) - e;
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic serial_load(input logic [7:0] v);
        for (int b = 7; b >= 0; b--) begin
            spd_pins[2] = v[b];
            repeat (4) @(negedge clk);
            spd_pins[1] = 1'b1;
            repeat (4) @(negedge clk);
            spd_pins[1] = 1'b0;
            repeat (4) @(negedge clk);
        end
        spd_pins[0] = 1'b1;
        repeat (4) @(negedge clk);
        spd_pins[0] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_field(input bit mid, input logic [7:0] mv);
        int n;
        n = lines_of(std_ccir);
        @(negedge clk) field_stb = 1'b1;
        @(negedge clk) field_stb = 1'b0;
        pulses = 0;
        bad_pos = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) begin line_stb = 1'b1; cur_line = i; end
            @(negedge clk) line_stb = 1'b0;
            if (mid && i == 3) serial_load(mv);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_field(input int expv, input string tag);
        n_vec++;
        if (pulses != expv || bad_pos) begin
            n_bad++;
            $display("FAIL %s: pulses=%0d contiguous=%0d expected pulses=%0d contiguous=1",
                     tag, pulses, !bad_pos, expv);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        n_vec++;
        if (xsub !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: xsub=%b expected 0", xsub);
        end
        rst_n = 1'b1;
        xsub_en = 1'b1;
        settle();
        // R10 / R6: serial value after reset is 00h, fastest shutter
        run_field(1'b0, 8'h00);
        check_field(262, "R10 R6 serial zero after reset");

        // R4 R5 R3: parallel sweep over both standards
        par_sel = 1'b1;
        for (int c = 0; c < 2; c++) begin
            for (int code = 0; code < 8; code++) begin
                std_ccir = c[0];
                spd_pins = code[2:0];
                settle();
                run_field(1'b0, 8'h00);
                check_field(k_of(exp_par(code, c[0]), c[0]),
                            $sformatf("R4 R5 parallel code %0d std %0d", code, c));
            end
        end

        // R6: serial values
        par_sel = 1'b0;
        spd_pins = 3'b000;
        begin
            logic [7:0] vals[8] = '{8'h4E, 8'h9C, 8'hED, 8'h4A, 8'h97, 8'hE1, 8'hFF, 8'h01};
            for (int j = 0; j < 8; j++) begin
                std_ccir = (j >= 3 && j <= 5);
                serial_load(vals[j]);
                settle();
                run_field(1'b0, 8'h00);
                check_field(k_of(int'(vals[j]), std_ccir),
                            $sformatf("R6 serial value %02h", vals[j]));
            end
        end

        // R8: mid-field load takes effect only at next boundary
        std_ccir = 1'b0;
        serial_load(8'h40);
        settle();
        run_field(1'b1, 8'h10);
        check_field(262 - 8'h40, "R8 field keeps old value after mid-field load");
        run_field(1'b0, 8'h00);
        check_field(262 - 8'h10, "R8 new value at next boundary");

        // R3: serial value ignored in parallel mode
        serial_load(8'h20);
        par_sel = 1'b1;
        spd_pins = 3'b100;
        settle();
        run_field(1'b0, 8'h00);
        check_field(262 - 16, "R3 serial value ignored in parallel mode");

        // R3: parallel pins ignored in serial mode (loaded value 20h governs)
        par_sel = 1'b0;
        settle();
        run_field(1'b0, 8'h00);
        check_field(262 - 8'h20, "R3 parallel code ignored in serial mode");

        // R9 R2: auto iris
        iris_sel = 1'b1;
        for (int f = 0; f < 8; f++) begin
            iris_bright = (f < 3);
            spd_pins = f[2:0];   // R2: speed pins must not matter
            settle();
            run_field(1'b0, 8'h00);
            if (iris_bright) ik = (ik + 1 > 262) ? 262 : ik + 1;
            else             ik = (ik == 0) ? 0 : ik - 1;
            check_field(ik, $sformatf("R9 R2 iris field %0d", f));
        end

        // R1: enable low stops discharge
        xsub_en = 1'b0;
        settle();
        run_field(1'b0, 8'h00);
        check_field(0, "R1 enable low");

        // R7: re-enable parallel, pulse placement on first K lines
        xsub_en = 1'b1;
        iris_sel = 1'b0;
        par_sel = 1'b1;
        std_ccir = 1'b1;
        spd_pins = 3'b111;
        settle();
        run_field(1'b0, 8'h00);
        check_field(312 - 130, "R7 R5 pulses on first K lines");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule